// File: doc/BRIEF.md
# Polled NVM Word Read Sequencer

This block reads one or more 16-bit words out of a non-volatile memory through a single 32-bit command/status register. A request gives a start word offset and a word count. The block first checks that the request fits inside the device. It then reads the words one at a time, at ascending addresses. For each word it writes a command that carries the word address and a start bit. It then reads the same register back until a completion flag appears, and takes the word from the upper half of the register.

Polling is bounded. Between two unsuccessful polls the block waits a fixed number of clock cycles. When the completion flag has not appeared after a set number of polls, the block abandons the request and raises an error. Words that were read before the failing one have already been delivered on the output stream. A request that fails the range check raises the error without issuing any command.

Top module: `nvm_word_reader`

## Requirements
- R1: After reset, `busy_o`, `err_o`, `word_valid_o`, `cmd_wr_o` and `poll_rd_o` are all low.
- R2: A start with `count_i` equal to zero, with `offset_i` >= DEPTH, or with `count_i` > DEPTH - `offset_i` is rejected. `err_o` is high in the following cycle, `busy_o` stays low, and no command is written.
- R3: Each command write carries `cmd_o` = (word address << 2) | 1. Bit 0 is the start bit, bit 1 is zero, the address field begins at bit 2, and all bits above the address field are zero.
- R4: The first poll strobe comes in the cycle after a command write. While the completion flag (status bit 1) is clear, consecutive poll strobes for the same word are exactly POLL_GAP + 1 cycles apart.
- R5: When a polled status has bit 1 set, `word_valid_o` pulses in the next cycle, with `word_o` equal to bits 31:16 of that status.
- R6: An accepted request delivers exactly `count_i` words, read from addresses `offset_i`, `offset_i`+1, and so on, in ascending order.
- R7: A word whose completion flag is still clear after MAX_POLLS polls ends the request. `err_o` is set, `busy_o` drops, and no further command is written.
- R8: `busy_o` is high from the cycle after an accepted start until the request ends. A start while `busy_o` is high has no effect.
- R9: `err_o` holds its value while the block is idle, and is recomputed by every start accepted while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken while idle |
| offset_i | input | 16 | First word address |
| count_i | input | 16 | Number of words |
| busy_o | output | 1 | Request in progress |
| err_o | output | 1 | Last request was rejected or timed out |
| word_o | output | 16 | Data word read |
| word_valid_o | output | 1 | `word_o` is valid this cycle |
| cmd_wr_o | output | 1 | Command register write strobe |
| cmd_o | output | 32 | Command word |
| poll_rd_o | output | 1 | Status register read strobe |
| status_i | input | 32 | Register value, sampled while `poll_rd_o` is high |

## Verification
The assertions assume that `status_i` is only meaningful in cycles where `poll_rd_o` is high, and that the register behind it reports completion only for the most recently written command. The range assertion also assumes that `offset_i` and `count_i` are steady in the cycle in which `start_i` is sampled. The bench's memory model meets these assumptions. Its completion flag depends only on the number of polls since the last command write. Request fields are driven together with `start_i` and change only at a falling clock edge.

// File: rtl/nvm_word_reader.sv
module nvm_word_reader #(
  parameter int DEPTH     = 16384,
  parameter int MAX_POLLS = 100000,
  parameter int POLL_GAP  = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [15:0] offset_i,
  input  logic [15:0] count_i,
  output logic        busy_o,
  output logic        err_o,
  output logic [15:0] word_o,
  output logic        word_valid_o,
  output logic        cmd_wr_o,
  output logic [31:0] cmd_o,
  output logic        poll_rd_o,
  input  logic [31:0] status_i
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = $clog2(MAX_POLLS + 1);
  localparam int GW = $clog2(POLL_GAP + 2);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_POLL, S_GAP} state_t;

  state_t        state;
  logic [AW-1:0] addr;
  logic [15:0]   left;
  logic [PW-1:0] polls;
  logic [GW-1:0] gap;
  logic          range_bad;
  logic          done_seen;

  wire unused_status = ^{status_i[15:2], status_i[0]};

  assign range_bad = (count_i == 16'd0) ||
                     ({1'b0, offset_i} >= 17'(DEPTH)) ||
                     ({1'b0, count_i} > (17'(DEPTH) - {1'b0, offset_i}));
  assign done_seen = status_i[1];
  assign busy_o    = (state != S_IDLE);
  assign cmd_wr_o  = (state == S_ISSUE);
  assign poll_rd_o = (state == S_POLL);
  assign cmd_o     = {{(30-AW){1'b0}}, addr, 2'b01};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      addr         <= '0;
      left         <= '0;
      polls        <= '0;
      gap          <= '0;
      err_o        <= 1'b0;
      word_o       <= '0;
      word_valid_o <= 1'b0;
    end else begin
      word_valid_o <= 1'b0;
      case (state)
        S_IDLE: if (start_i) begin
          err_o <= range_bad;
          if (!range_bad) begin
            addr  <= offset_i[AW-1:0];
            left  <= count_i;
            state <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          polls <= '0;
          state <= S_POLL;
        end
        S_POLL: begin
          if (done_seen) begin
            word_o       <= status_i[31:16];
            word_valid_o <= 1'b1;
            if (left == 16'd1) begin
              state <= S_IDLE;
            end else begin
              addr  <= addr + AW'(1);
              left  <= left - 16'd1;
              state <= S_ISSUE;
            end
          end else if (polls == PW'(MAX_POLLS - 1)) begin
            err_o <= 1'b1;
            state <= S_IDLE;
          end else begin
            polls <= polls + PW'(1);
            gap   <= GW'(1);
            state <= (POLL_GAP == 0) ? S_POLL : S_GAP;
          end
        end
        S_GAP: begin
          if (gap == GW'(POLL_GAP)) state <= S_POLL;
          else gap <= gap + GW'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nvm_word_reader_chk.sv
module nvm_word_reader_chk #(
  parameter int DEPTH     = 16384,
  parameter int MAX_POLLS = 100000,
  parameter int POLL_GAP  = 1000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic [15:0] offset_i,
  input logic [15:0] count_i,
  input logic        busy_o,
  input logic        err_o,
  input logic [15:0] word_o,
  input logic        word_valid_o,
  input logic        cmd_wr_o,
  input logic [31:0] cmd_o,
  input logic        poll_rd_o,
  input logic [31:0] status_i
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [31:0] polls_since_cmd;
  logic [31:0] idle_since_poll;
  logic        bad_req;

  assign bad_req = (count_i == 16'd0) || (int'(offset_i) >= DEPTH) ||
                   (int'(count_i) > DEPTH - int'(offset_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      polls_since_cmd <= '0;
      idle_since_poll <= '0;
    end else begin
      if (cmd_wr_o) polls_since_cmd <= '0;
      else if (poll_rd_o) polls_since_cmd <= polls_since_cmd + 32'd1;
      if (poll_rd_o) idle_since_poll <= '0;
      else if (idle_since_poll != 32'hFFFF_FFFF) idle_since_poll <= idle_since_poll + 32'd1;
    end
  end

  p_cmd_fmt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_o |-> (cmd_o[1:0] == 2'b01) && ((cmd_o >> (AW + 2)) == 32'd0));

  p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !cmd_wr_o && !poll_rd_o);

  p_poll_follows_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_o |=> poll_rd_o);

  p_poll_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rd_o && polls_since_cmd != 32'd0) |-> (idle_since_poll == 32'(POLL_GAP)));

  p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_rd_o |-> (polls_since_cmd < 32'(MAX_POLLS)));

  p_word_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rd_o && status_i[1]) |=> word_valid_o && (word_o == $past(status_i[31:16])));

  p_range_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && bad_req) |=> err_o && !busy_o);

  p_err_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> !busy_o);
endmodule

bind nvm_word_reader nvm_word_reader_chk #(
  .DEPTH(DEPTH), .MAX_POLLS(MAX_POLLS), .POLL_GAP(POLL_GAP)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .offset_i(offset_i),
  .count_i(count_i), .busy_o(busy_o), .err_o(err_o), .word_o(word_o),
  .word_valid_o(word_valid_o), .cmd_wr_o(cmd_wr_o), .cmd_o(cmd_o),
  .poll_rd_o(poll_rd_o), .status_i(status_i)
);

// File: tb/nvm_word_reader_tb_top.sv
module nvm_word_reader_tb_top;
  localparam int DEPTH = 8;
  localparam int MAXP  = 4;
  localparam int GAP   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] offset_i = '0;
  logic [15:0] count_i = '0;
  logic        busy_o, err_o, word_valid_o, cmd_wr_o, poll_rd_o;
  logic [15:0] word_o;
  logic [31:0] cmd_o, status_i;

  always #2.5 clk = ~clk;

  nvm_word_reader #(.DEPTH(DEPTH), .MAX_POLLS(MAXP), .POLL_GAP(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .offset_i(offset_i),
    .count_i(count_i), .busy_o(busy_o), .err_o(err_o), .word_o(word_o),
    .word_valid_o(word_valid_o), .cmd_wr_o(cmd_wr_o), .cmd_o(cmd_o),
    .poll_rd_o(poll_rd_o), .status_i(status_i)
  );

  int total = 0;
  int bad = 0;

  function automatic logic [15:0] mem_word(int a);
    return 16'hC35A ^ 16'(a * 16'h0101) ^ 16'(a << 12);
  endfunction

  // memory model: completion appears on the lat-th poll after a command
  int lat = 1;
  int stuck = -1;
  int m_addr = 0;
  int m_polls = 0;
  always @(posedge clk) begin
    if (cmd_wr_o) begin
      m_addr  <= int'(cmd_o[15:2]);
      m_polls <= 0;
    end else if (poll_rd_o) begin
      m_polls <= m_polls + 1;
    end
  end
  always_comb begin
    status_i = 32'h0000_0000;
    if (m_addr != stuck && m_polls + 1 >= lat)
      status_i = {mem_word(m_addr), 14'h0, 1'b1, 1'b0};
  end

  // monitor
  int run_off = 0;
  int base_cmd = 0, base_word = 0;
  int n_cmd = 0, n_poll = 0, n_word = 0;
  int cmd_mis = 0, word_mis = 0, gap_mis = 0;
  int cyc = 0, last_poll = -1;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cmd_wr_o) begin
      if (cmd_o != ((32'(run_off + n_cmd - base_cmd)) << 2 | 32'd1)) cmd_mis <= cmd_mis + 1;
      n_cmd <= n_cmd + 1;
      last_poll <= -1;
    end
    if (poll_rd_o) begin
      if (last_poll >= 0 && cyc - last_poll != GAP + 1) gap_mis <= gap_mis + 1;
      last_poll <= cyc;
      n_poll <= n_poll + 1;
    end
    if (word_valid_o) begin
      if (word_o != mem_word(run_off + n_word - base_word)) word_mis <= word_mis + 1;
      n_word <= n_word + 1;
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic run(int off, int cnt, int l, int s, bit mid_start);
    int c0, p0, w0, cm0, wm0, gm0;
    int in_range, exp_words, exp_cmds, exp_polls, exp_err, k;
    @(negedge clk);
    lat = l; stuck = s; run_off = off;
    c0 = n_cmd; p0 = n_poll; w0 = n_word; cm0 = cmd_mis; wm0 = word_mis; gm0 = gap_mis;
    base_cmd = n_cmd; base_word = n_word;
    start_i = 1'b1; offset_i = 16'(off); count_i = 16'(cnt);
    @(negedge clk);
    start_i = 1'b0;
    k = 0;
    while (busy_o && k < 1000) begin
      if (mid_start && k == 5) begin
        start_i = 1'b1; offset_i = 16'd0; count_i = 16'd1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    start_i = 1'b0;
    @(negedge clk);
    in_range = (cnt != 0) && (off < DEPTH) && (cnt <= DEPTH - off);
    if (!in_range) begin
      exp_words = 0; exp_cmds = 0; exp_polls = 0; exp_err = 1;
    end else if (l > MAXP) begin
      exp_words = 0; exp_cmds = 1; exp_polls = MAXP; exp_err = 1;
    end else if (s >= off && s < off + cnt) begin
      exp_words = s - off; exp_cmds = s - off + 1;
      exp_polls = (s - off) * l + MAXP; exp_err = 1;
    end else begin
      exp_words = cnt; exp_cmds = cnt; exp_polls = cnt * l; exp_err = 0;
    end
    if (!in_range) check("R2 rejected request issues no command", n_cmd - c0, 0);
    else check("R6 command count", n_cmd - c0, exp_cmds);
    check(exp_err && in_range ? "R7 error after poll limit" : (in_range ? "R9 error cleared" : "R2 error on bad range"),
          int'(err_o), exp_err);
    check("R6 word count", n_word - w0, exp_words);
    check("R5 word data", word_mis - wm0, 0);
    check("R3 command format", cmd_mis - cm0, 0);
    check("R4 poll count", n_poll - p0, exp_polls);
    check("R4 poll spacing", gap_mis - gm0, 0);
    check("R8 busy dropped", int'(busy_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy at reset", int'(busy_o), 0);
    check("R1 err at reset", int'(err_o), 0);
    check("R1 valid at reset", int'(word_valid_o), 0);
    check("R1 strobes at reset", int'(cmd_wr_o) + int'(poll_rd_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R6: sweep all offsets and counts, including out-of-range ones
    for (int o = 0; o <= DEPTH + 1; o++)
      for (int c = 0; c <= DEPTH + 1; c++)
        run(o, c, 1, -1, 1'b0);

    // R4 R5: slower completion
    for (int l = 2; l <= MAXP; l++) run(0, DEPTH, l, -1, 1'b0);

    // R7: stuck word at every position, then recovery (R9)
    for (int s = 0; s < DEPTH; s++) begin
      run(0, DEPTH, 2, s, 1'b0);
      repeat (4) @(negedge clk);
      check("R9 error held while idle", int'(err_o), 1);
      run(s, 1, 1, -1, 1'b0);
    end
    run(2, 3, MAXP + 1, -1, 1'b0);

    // R8: start while busy is ignored
    run(1, 6, 2, -1, 1'b1);
    run(3, 4, 3, 5, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule